// File: doc/BRIEF.md
# Speculative Switch Allocator

This block is the switch-allocation stage of a virtual-channel router. Every input virtual channel (VC) may present one request for an output port in each cycle. A head flit requests speculatively: it bids for the switch in the same cycle as it bids for an output VC, on the bet that the VC bid will win. Body and tail flits, and head flits that already hold a VC, request non-speculatively. The outcome of that cycle's VC allocation arrives as an input, one bit per input VC.

Two separable allocators run side by side, one for each request class. Each has two stages of round-robin arbiters: the first picks one VC per input port, and the second picks one input per output port. At every output the non-speculative winner takes precedence. A speculative winner is used only if three conditions hold: the output has no non-speculative winner, its VC allocation succeeded, and its input port received no non-speculative grant anywhere. When a speculative grant is thrown away, the output stays idle for that cycle. A grant pulse is issued only for a grant that is used, and only a used grant moves the round-robin priority.

The results are registered. These are a one-hot crossbar select for each output and a grant pulse for each input VC, and both appear one clock after the requests. The VC allocator, the flit buffers and the crossbar datapath are outside the block. The requester must re-issue any request that was not granted.

Top module: `spec_sw_alloc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `vc_grant` and `xbar_sel` are all zero. Every round-robin pointer starts at index 0, so index 0 has the highest priority in the first arbitration.
- R2: Input VC k = port*NUM_VCS + vc drives `req_valid[k]`, `req_spec[k]` and `va_ok[k]`, and its target output is `req_port[k*PORT_W +: PORT_W]`. Results appear on the edge after the requests are sampled. `vc_grant[k]` is high only when VC k requested in the previous cycle.
- R3: `xbar_sel[o*NUM_PORTS +: NUM_PORTS]` is the select for output o, with bit i meaning input port i. Each output selects at most one input, each input feeds at most one output, and each input port gets at most one VC grant. The number of VC grants at an input port equals the number of outputs that select that port.
- R4: A non-speculative winner at an output is always chosen over a speculative winner at the same output.
- R5: A speculative winner whose `va_ok` bit is 0 is discarded. The output is idle, no grant pulse is issued, and that class's pointers do not move.
- R6: If an input port receives a non-speculative grant, its speculative first-stage winner is discarded in the same cycle.
- R7: Within a class, the first stage at each input port chooses among requesting VCs in round-robin order. After VC g is used, the search starts at VC g+1 (wrapping).
- R8: Within a class, the second stage at each output chooses among input ports in round-robin order. After input i is used, the search starts at input i+1 (wrapping).
- R9: A pointer moves only when its winner is actually granted. Winners that lose, or that are discarded, leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS*NUM_VCS | Request present, one bit per input VC |
| req_spec | input | NUM_PORTS*NUM_VCS | 1 = speculative request, 0 = non-speculative |
| req_port | input | NUM_PORTS*NUM_VCS*PORT_W | Requested output port per input VC |
| va_ok | input | NUM_PORTS*NUM_VCS | VC allocation succeeded this cycle, per input VC |
| vc_grant | output | NUM_PORTS*NUM_VCS | Registered grant pulse per input VC |
| xbar_sel | output | NUM_PORTS*NUM_PORTS | Registered one-hot input select per output |

## Verification
The assertions check the matching rules on every cycle. Crossbar rows and columns are at most one-hot, each port gets at most one grant, grants agree with selects, a grant needs a request in the previous cycle, and a speculative grant needs a successful VC allocation. Other behaviour depends on history across cycles or on comparing the two classes. This covers the rotation of both arbiter stages, the rule that pointers stay put after a discarded or lost win, and non-speculative precedence at a contended output. Only the bench can show these. It does so with directed scenarios and a long random run against a cycle-level reference model.

// File: rtl/swa_pkg.sv
package swa_pkg;
  typedef enum logic {
    CLS_NS = 1'b0,
    CLS_SP = 1'b1
  } req_class_e;
endpackage

// File: rtl/swa_rr_arb.sv
module swa_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] gnt,
  output logic         any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] win_idx;

  always_comb begin
    int j;
    gnt     = '0;
    win_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt[j]  = 1'b1;
        win_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (upd && any) begin
      ptr <= (int'(win_idx) == N - 1) ? '0 : win_idx + 1'b1;
    end
  end

  AST_ARB_GNT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0); // R2
  AST_ARB_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ptr)); // R9
endmodule

// File: rtl/swa_class_alloc.sv
module swa_class_alloc #(
  parameter int P  = 5,
  parameter int V  = 4,
  parameter int PW = $clog2(P),
  parameter int VW = $clog2(V)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [P*V-1:0]  req,
  input  logic [P*V*PW-1:0] port_f,
  input  logic [P-1:0]    use_in,
  input  logic [P-1:0]    use_out,
  output logic [P*VW-1:0] win_vc,
  output logic [P-1:0]    win_any,
  output logic [P*P-1:0]  out_gnt,
  output logic [P-1:0]    out_any
);
  logic [P*V-1:0]  in_gnt;
  logic [P*PW-1:0] win_port;
  logic [P*P-1:0]  out_req;
  logic [P*P-1:0]  gnt_col;

  // first stage: one VC per input port
  for (genvar p = 0; p < P; p++) begin : g_in
    swa_rr_arb #(.N(V)) i_in_arb (
      .clk (clk),
      .rst (rst),
      .req (req[p*V +: V]),
      .upd (use_in[p]),
      .gnt (in_gnt[p*V +: V]),
      .any (win_any[p])
    );
  end

  always_comb begin
    win_vc   = '0;
    win_port = '0;
    for (int p = 0; p < P; p++) begin
      for (int v = 0; v < V; v++) begin
        if (in_gnt[p*V + v]) begin
          win_vc[p*VW +: VW]   = VW'(v);
          win_port[p*PW +: PW] = port_f[(p*V + v)*PW +: PW];
        end
      end
    end
  end

  always_comb begin
    out_req = '0;
    gnt_col = '0;
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < P; i++) begin
        out_req[o*P + i] = win_any[i] && (win_port[i*PW +: PW] == PW'(o));
        gnt_col[i*P + o] = out_gnt[o*P + i];
      end
    end
  end

  // second stage: one input port per output
  for (genvar o = 0; o < P; o++) begin : g_out
    swa_rr_arb #(.N(P)) i_out_arb (
      .clk (clk),
      .rst (rst),
      .req (out_req[o*P +: P]),
      .upd (use_out[o]),
      .gnt (out_gnt[o*P +: P]),
      .any (out_any[o])
    );
  end

  for (genvar i = 0; i < P; i++) begin : g_chk
    AST_CLASS_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt_col[i*P +: P])); // R3
  end
endmodule

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS),
  parameter int VC_W      = $clog2(NUM_VCS)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PORTS*NUM_VCS-1:0]        req_valid,
  input  logic [NUM_PORTS*NUM_VCS-1:0]        req_spec,
  input  logic [NUM_PORTS*NUM_VCS*PORT_W-1:0] req_port,
  input  logic [NUM_PORTS*NUM_VCS-1:0]        va_ok,
  output logic [NUM_PORTS*NUM_VCS-1:0]        vc_grant,
  output logic [NUM_PORTS*NUM_PORTS-1:0]      xbar_sel
);
  import swa_pkg::*;

  localparam int P  = NUM_PORTS;
  localparam int V  = NUM_VCS;
  localparam int NK = P * V;

  logic [NK-1:0]     ns_req, sp_req;
  logic [P*VC_W-1:0] ns_win_vc, sp_win_vc;
  logic [P-1:0]      ns_win_any, sp_win_any;
  logic [P*P-1:0]    ns_out_gnt, sp_out_gnt;
  logic [P-1:0]      ns_any, sp_any;
  logic [P-1:0]      ns_in_hit, sp_in_used, sp_out_used;
  logic [P*P-1:0]    sp_keep;
  logic [P*P-1:0]    sel_next;
  logic [NK-1:0]     grant_next;
  logic [P*P-1:0]    sel_col;

  always_comb begin
    for (int k = 0; k < NK; k++) begin
      ns_req[k] = req_valid[k] && (req_class_e'(req_spec[k]) == CLS_NS);
      sp_req[k] = req_valid[k] && (req_class_e'(req_spec[k]) == CLS_SP);
    end
  end

  swa_class_alloc #(.P(P), .V(V), .PW(PORT_W), .VW(VC_W)) i_ns_alloc (
    .clk     (clk),
    .rst     (rst),
    .req     (ns_req),
    .port_f  (req_port),
    .use_in  (ns_in_hit),
    .use_out (ns_any),
    .win_vc  (ns_win_vc),
    .win_any (ns_win_any),
    .out_gnt (ns_out_gnt),
    .out_any (ns_any)
  );

  swa_class_alloc #(.P(P), .V(V), .PW(PORT_W), .VW(VC_W)) i_sp_alloc (
    .clk     (clk),
    .rst     (rst),
    .req     (sp_req),
    .port_f  (req_port),
    .use_in  (sp_in_used),
    .use_out (sp_out_used),
    .win_vc  (sp_win_vc),
    .win_any (sp_win_any),
    .out_gnt (sp_out_gnt),
    .out_any (sp_any)
  );

  // merge the two classes: non-speculative first, speculative only if usable
  always_comb begin
    ns_in_hit   = '0;
    sp_keep     = '0;
    sel_next    = '0;
    grant_next  = '0;
    sp_in_used  = '0;
    sp_out_used = '0;
    for (int i = 0; i < P; i++) begin
      for (int o = 0; o < P; o++) begin
        if (ns_out_gnt[o*P + i]) ns_in_hit[i] = ns_win_any[i];
      end
    end
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < P; i++) begin
        if (!ns_any[o] && sp_any[o] && sp_out_gnt[o*P + i] && sp_win_any[i] &&
            !ns_in_hit[i] && va_ok[i*V + int'(sp_win_vc[i*VC_W +: VC_W])]) begin
          sp_keep[o*P + i] = 1'b1;
        end
      end
      sel_next[o*P +: P] = ns_any[o] ? ns_out_gnt[o*P +: P] : sp_keep[o*P +: P];
      sp_out_used[o]     = |sp_keep[o*P +: P];
    end
    for (int i = 0; i < P; i++) begin
      for (int o = 0; o < P; o++) begin
        if (sp_keep[o*P + i]) sp_in_used[i] = 1'b1;
      end
      if (ns_in_hit[i]) grant_next[i*V + int'(ns_win_vc[i*VC_W +: VC_W])] = 1'b1;
      if (sp_in_used[i]) grant_next[i*V + int'(sp_win_vc[i*VC_W +: VC_W])] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vc_grant <= '0;
      xbar_sel <= '0;
    end else begin
      vc_grant <= grant_next;
      xbar_sel <= sel_next;
    end
  end

  always_comb begin
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < P; i++) begin
        sel_col[i*P + o] = xbar_sel[o*P + i];
      end
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_row_chk
    AST_SEL_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(xbar_sel[o*P +: P])); // R3
  end

  for (genvar i = 0; i < P; i++) begin : g_port_chk
    AST_SEL_COL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_col[i*P +: P])); // R3
    AST_GRANT_PER_PORT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(vc_grant[i*V +: V])); // R3
    AST_GRANT_MATCH_SEL: assert property (@(posedge clk) disable iff (rst)
      $countones(vc_grant[i*V +: V]) == $countones(sel_col[i*P +: P])); // R3
  end

  for (genvar k = 0; k < NK; k++) begin : g_vc_chk
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
      vc_grant[k] |-> $past(req_valid[k])); // R2
    AST_SPEC_NEEDS_VC: assert property (@(posedge clk) disable iff (rst)
      (vc_grant[k] && $past(req_spec[k])) |-> $past(va_ok[k])); // R5
  end
endmodule

// File: tb/test_spec_sw_alloc.sv
module test_spec_sw_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 5;
  localparam int V  = 4;
  localparam int PW = 3;
  localparam int NK = P * V;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NK-1:0]   req_valid = '0;
  logic [NK-1:0]   req_spec  = '0;
  logic [NK*PW-1:0] req_port = '0;
  logic [NK-1:0]   va_ok     = '0;
  logic [NK-1:0]   vc_grant;
  logic [P*P-1:0]  xbar_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_tag = "R1";
  int ptr1[2][P];
  int ptr2[2][P];
  logic [NK-1:0]  exp_grant;
  logic [P*P-1:0] exp_sel;

  spec_sw_alloc #(.NUM_PORTS(P), .NUM_VCS(V)) i_spec_sw_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_spec(req_spec),
    .req_port(req_port), .va_ok(va_ok), .vc_grant(vc_grant), .xbar_sel(xbar_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_reqs();
    req_valid = '0; req_spec = '0; req_port = '0; va_ok = '0;
  endtask

  task automatic set_req(int i, int v, int port, bit spec, bit ok);
    req_valid[i*V+v] = 1'b1;
    req_spec[i*V+v]  = spec;
    req_port[(i*V+v)*PW +: PW] = PW'(port);
    va_ok[i*V+v] = ok;
  endtask

  // reference model of the requirements: expected outputs and pointer moves
  task automatic model_eval();
    int w1[2][P];
    int w2[2][P];
    bit nsgot[P];
    int v, idx, i;
    exp_grant = '0;
    exp_sel   = '0;
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < P; p++) begin
        w1[c][p] = -1;
        for (int k = 0; k < V; k++) begin
          v = (ptr1[c][p] + k) % V;
          idx = p*V + v;
          if (w1[c][p] < 0 && req_valid[idx] && (int'(req_spec[idx]) == c)) w1[c][p] = v;
        end
      end
      for (int o = 0; o < P; o++) begin
        w2[c][o] = -1;
        for (int k = 0; k < P; k++) begin
          i = (ptr2[c][o] + k) % P;
          if (w2[c][o] < 0 && w1[c][i] >= 0 &&
              int'(req_port[(i*V + w1[c][i])*PW +: PW]) == o) w2[c][o] = i;
        end
      end
    end
    for (int n = 0; n < P; n++) begin
      nsgot[n] = 1'b0;
      for (int o = 0; o < P; o++) if (w2[0][o] == n) nsgot[n] = 1'b1;
    end
    for (int o = 0; o < P; o++) begin
      if (w2[0][o] >= 0) begin
        i = w2[0][o];
        exp_sel[o*P+i] = 1'b1;
        exp_grant[i*V + w1[0][i]] = 1'b1;
        ptr2[0][o] = (i + 1) % P;
        ptr1[0][i] = (w1[0][i] + 1) % V;
      end else if (w2[1][o] >= 0) begin
        i = w2[1][o];
        if (!nsgot[i] && va_ok[i*V + w1[1][i]]) begin
          exp_sel[o*P+i] = 1'b1;
          exp_grant[i*V + w1[1][i]] = 1'b1;
          ptr2[1][o] = (i + 1) % P;
          ptr1[1][i] = (w1[1][i] + 1) % V;
        end
      end
    end
  endtask

  task automatic step();
    model_eval();
    @(negedge clk);
    check(cur_tag, "vc_grant", 64'(vc_grant), 64'(exp_grant));
    check(cur_tag, "xbar_sel", 64'(xbar_sel), 64'(exp_sel));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 2; c++) for (int p = 0; p < P; p++) begin
      ptr1[c][p] = 0; ptr2[c][p] = 0;
    end
    repeat (3) @(negedge clk);
    set_req(0, 1, 0, 1'b0, 1'b0);
    @(negedge clk);
    // R1: outputs stay zero while reset is held, despite a request
    check("R1", "vc_grant in reset", 64'(vc_grant), 64'd0);
    check("R1", "xbar_sel in reset", 64'(xbar_sel), 64'd0);
    clear_reqs();
    rst = 1'b0;
    // R1: pointers start at index 0
    cur_tag = "R1";
    for (int v = 0; v < V; v++) set_req(0, v, 0, 1'b0, 1'b0);
    step();
    // R2: single request, one-cycle latency, field positions
    cur_tag = "R2";
    clear_reqs(); set_req(2, 3, 4, 1'b0, 1'b0); step();
    clear_reqs(); step();
    // R4: non-speculative beats speculative at the same output
    cur_tag = "R4";
    set_req(1, 0, 2, 1'b1, 1'b1); set_req(3, 1, 2, 1'b0, 1'b0); step();
    // R5: failed VC allocation discards the speculative grant
    cur_tag = "R5";
    clear_reqs(); set_req(4, 2, 1, 1'b1, 1'b0); step();
    step();
    clear_reqs(); set_req(4, 2, 1, 1'b1, 1'b1); set_req(4, 3, 1, 1'b1, 1'b1); step();
    // R6: a non-speculative grant at an input cancels its speculative win
    cur_tag = "R6";
    clear_reqs(); set_req(1, 0, 0, 1'b0, 1'b0); set_req(1, 1, 2, 1'b1, 1'b1); step();
    // R7: VC rotation at one input
    cur_tag = "R7";
    clear_reqs();
    for (int v = 0; v < V; v++) set_req(0, v, v, 1'b0, 1'b0);
    repeat (V + 1) step();
    // R8: input rotation at one output
    cur_tag = "R8";
    clear_reqs();
    for (int i = 0; i < P; i++) set_req(i, 0, 3, 1'b0, 1'b0);
    repeat (P + 1) step();
    // R3: full load, matching limits
    cur_tag = "R3";
    for (int n = 0; n < 6; n++) begin
      clear_reqs();
      for (int i = 0; i < P; i++) for (int v = 0; v < V; v++)
        set_req(i, v, int'($urandom % P), 1'b0, 1'b0);
      step();
    end
    // R9: random mix of classes and VC outcomes
    cur_tag = "R9";
    for (int n = 0; n < 3000; n++) begin
      clear_reqs();
      for (int i = 0; i < P; i++) for (int v = 0; v < V; v++)
        if ($urandom % 100 < 40)
          set_req(i, v, int'($urandom % P), 1'($urandom % 2), 1'($urandom % 100 < 60));
      step();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule